// File: doc/BRIEF.md
# Dual-Clock FIFO with Per-Entry Status Synchronization

This block moves a stream of data words from one clock domain into a second, unrelated one. Storage is a small ring of entries. Two one-hot ring pointers address it, one per domain, and each advances by one place on every accepted operation. The two domains never compare their pointers. Each entry instead has an occupancy state. The write side flips a write flag for an entry when it fills the entry, and the read side flips a read flag when it takes the entry. The entry is occupied while the two flags differ.

Each flag crosses to the other domain through its own chain of synchronizer flops. The read domain reports `empty` when the entry under its read pointer is not occupied. The write domain reports `full` when any entry from its write pointer up to `SYNC_STAGES` places ahead of it is occupied. Writes therefore stop with a guard of `SYNC_STAGES` free entries, which leaves `DEPTH - SYNC_STAGES` usable entries. Read data is registered. An AND-OR selection, gated by the one-hot read pointer, picks the entry.

Each domain has its own active-low reset. The reset asserts asynchronously and releases synchronously to that domain's clock. Both resets are expected to be applied together.

Top module: `ring_status_fifo`

## Requirements
- R1: Each pointer is one-hot and starts at entry 0 after reset. It moves one entry around the ring per accepted operation, so entries are filled and drained in ring order across any number of wraps.
- R2: A write is accepted only on a `wr_clk` rising edge where `wr_en` is 1 and `full` is 0. A word offered while `full` is 1 is not stored and never appears at `rd_data`.
- R3: A read is accepted only on a `rd_clk` rising edge where `rd_en` is 1 and `empty` is 0. `rd_data` takes the entry's word on that same edge and otherwise holds its value. A read request while `empty` is 1 leaves `rd_data` unchanged.
- R4: After reset, `empty` is 1, `full` is 0 and `rd_data` is 0.
- R5: Words leave in the order they were accepted, with none lost and none repeated. Once the last stored word is taken, `empty` is 1 by the next `rd_clk` falling edge.
- R6: With no reads, exactly `DEPTH - SYNC_STAGES` writes are accepted (6 with the defaults) and `full` then stays 1.
- R7: After a write into an empty FIFO, `empty` falls after exactly `SYNC_STAGES` `rd_clk` rising edges following the accepting `wr_clk` edge, provided the two clocks' edges never coincide.
- R8: After one read from a full FIFO, `full` falls after exactly `SYNC_STAGES` `wr_clk` rising edges following the accepting `rd_clk` edge, provided the two clocks' edges never coincide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-domain clock |
| wr_arst_n | input | 1 | Write-domain reset, active low, asynchronous assertion |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Word to store |
| full | output | 1 | No further writes are accepted |
| rd_clk | input | 1 | Read-domain clock |
| rd_arst_n | input | 1 | Read-domain reset, active low, asynchronous assertion |
| rd_en | input | 1 | Read request |
| rd_data | output | WIDTH | Registered word from the last accepted read |
| empty | output | 1 | No stored word is visible to the read side |

## Verification
A pointer that skipped an entry or a flag that flipped twice shows up at `rd_data` as an out-of-order, missing or repeated word, at the latest on the first read that reaches that entry. A wrong guard window or a stuck synchronizer shows within one fill: the number of writes accepted before `full` rises is not `DEPTH - SYNC_STAGES`, or a refused word later appears at the output. The latency of `empty` falling and of `full` releasing is counted in edges of the other domain's clock, so a missing or extra synchronizer stage shows on the first word or on the first release.

// File: rtl/rsf_pkg.sv
package rsf_pkg;

  // Free entries kept ahead of the write pointer to cover the crossing delay.
  function automatic int unsigned guard_slots(input int unsigned stages);
    return stages;
  endfunction

  // Entries that can hold data at once.
  function automatic int unsigned usable_slots(input int unsigned depth,
                                               input int unsigned stages);
    return depth - guard_slots(stages);
  endfunction

endpackage

// File: rtl/rsf_rst_sync.sv
// Active-low reset: asserts at once, deasserts after STAGES clock edges.
module rsf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n = chain_q[STAGES-1];

endmodule

// File: rtl/rsf_ring_ptr.sv
// One-hot pointer that rotates by one place when step is high.
module rsf_ring_ptr #(
  parameter int unsigned SLOTS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [SLOTS-1:0] ptr
);

  localparam logic [SLOTS-1:0] HOME = {{(SLOTS-1){1'b0}}, 1'b1};

  logic [SLOTS-1:0] ptr_q;
  logic [SLOTS-1:0] ptr_d;

  always_comb begin
    if (step) begin
      ptr_d = {ptr_q[SLOTS-2:0], ptr_q[SLOTS-1]};
    end else begin
      ptr_d = ptr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= HOME;
    end else begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr = ptr_q;

endmodule

// File: rtl/rsf_bit_sync.sv
// A bank of independent multi-flop synchronizers, one chain per bit.
module rsf_bit_sync #(
  parameter int unsigned BITS   = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [BITS-1:0] din,
  output logic [BITS-1:0] dout
);

  for (genvar b = 0; b < BITS; b++) begin : g_bit
    logic [STAGES-1:0] stg_q;
    logic [STAGES-1:0] stg_d;

    always_comb begin
      stg_d = {stg_q[STAGES-2:0], din[b]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_q <= '0;
      end else begin
        stg_q <= stg_d;
      end
    end

    assign dout[b] = stg_q[STAGES-1];
  end

endmodule

// File: rtl/ring_status_fifo.sv
// Dual-clock FIFO: per-entry occupancy flags, one-hot ring pointers.
// DEPTH must exceed SYNC_STAGES + 1; SYNC_STAGES must be at least 2.
module ring_status_fifo #(
  parameter int unsigned DEPTH       = 8,
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             wr_clk,
  input  logic             wr_arst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic             full,
  input  logic             rd_clk,
  input  logic             rd_arst_n,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty
);

  localparam int unsigned GUARD = rsf_pkg::guard_slots(SYNC_STAGES);

  logic             wr_rst_n;
  logic             rd_rst_n;
  logic             wr_go;
  logic             rd_go;
  logic [DEPTH-1:0] wr_ptr;
  logic [DEPTH-1:0] rd_ptr;
  logic [DEPTH-1:0] wr_flag_q;
  logic [DEPTH-1:0] wr_flag_d;
  logic [DEPTH-1:0] rd_flag_q;
  logic [DEPTH-1:0] rd_flag_d;
  logic [DEPTH-1:0] wr_flag_at_rd;
  logic [DEPTH-1:0] rd_flag_at_wr;
  logic [DEPTH-1:0] wr_view;
  logic [DEPTH-1:0] rd_view;
  logic [DEPTH-1:0] guard_win;
  logic [WIDTH-1:0] pick_acc [DEPTH+1];
  logic [WIDTH-1:0] rd_data_q;
  logic [WIDTH-1:0] rd_data_d;

  // Reset release, one synchronizer per domain.
  rsf_rst_sync #(.STAGES(SYNC_STAGES)) u_wr_rst (
    .clk    (wr_clk),
    .arst_n (wr_arst_n),
    .rst_n  (wr_rst_n)
  );

  rsf_rst_sync #(.STAGES(SYNC_STAGES)) u_rd_rst (
    .clk    (rd_clk),
    .arst_n (rd_arst_n),
    .rst_n  (rd_rst_n)
  );

  // Ring pointers.
  rsf_ring_ptr #(.SLOTS(DEPTH)) u_wr_ptr (
    .clk   (wr_clk),
    .rst_n (wr_rst_n),
    .step  (wr_go),
    .ptr   (wr_ptr)
  );

  rsf_ring_ptr #(.SLOTS(DEPTH)) u_rd_ptr (
    .clk   (rd_clk),
    .rst_n (rd_rst_n),
    .step  (rd_go),
    .ptr   (rd_ptr)
  );

  // Per-entry flags: the write side flips its flag on fill, the read side on drain.
  always_comb begin
    wr_flag_d = wr_flag_q ^ ({DEPTH{wr_go}} & wr_ptr);
    rd_flag_d = rd_flag_q ^ ({DEPTH{rd_go}} & rd_ptr);
  end

  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) begin
      wr_flag_q <= '0;
    end else begin
      wr_flag_q <= wr_flag_d;
    end
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      rd_flag_q <= '0;
    end else begin
      rd_flag_q <= rd_flag_d;
    end
  end

  // Each flag crosses into the opposite domain on its own chain.
  rsf_bit_sync #(.BITS(DEPTH), .STAGES(SYNC_STAGES)) u_wr_to_rd (
    .clk   (rd_clk),
    .rst_n (rd_rst_n),
    .din   (wr_flag_q),
    .dout  (wr_flag_at_rd)
  );

  rsf_bit_sync #(.BITS(DEPTH), .STAGES(SYNC_STAGES)) u_rd_to_wr (
    .clk   (wr_clk),
    .rst_n (wr_rst_n),
    .din   (rd_flag_q),
    .dout  (rd_flag_at_wr)
  );

  // Occupancy as each domain sees it.
  assign wr_view = wr_flag_q ^ rd_flag_at_wr;
  assign rd_view = wr_flag_at_rd ^ rd_flag_q;

  // Guard window: the write pointer and the GUARD entries after it.
  for (genvar i = 0; i < DEPTH; i++) begin : g_win
    logic [GUARD:0] taps;
    for (genvar k = 0; k <= GUARD; k++) begin : g_tap
      localparam int unsigned SRC = (i + DEPTH - k) % DEPTH;
      assign taps[k] = wr_ptr[SRC];
    end
    assign guard_win[i] = |taps;
  end

  assign full  = |(wr_view & guard_win);
  assign empty = ~|(rd_view & rd_ptr);
  assign wr_go = wr_en & ~full;
  assign rd_go = rd_en & ~empty;

  // Storage entries with write enables, and the AND-OR read selection.
  assign pick_acc[0] = '0;
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [WIDTH-1:0] word_q;
    logic             load;

    assign load = wr_go & wr_ptr[i];

    always_ff @(posedge wr_clk) begin
      if (load) begin
        word_q <= wr_data;
      end
    end

    assign pick_acc[i+1] = pick_acc[i] | ({WIDTH{rd_ptr[i]}} & word_q);
  end

  always_comb begin
    if (rd_go) begin
      rd_data_d = pick_acc[DEPTH];
    end else begin
      rd_data_d = rd_data_q;
    end
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      rd_data_q <= '0;
    end else begin
      rd_data_q <= rd_data_d;
    end
  end

  assign rd_data = rd_data_q;

endmodule

// File: rtl/ring_status_fifo_checker.sv
module ring_status_fifo_checker #(
  parameter int unsigned DEPTH       = 8,
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic             wr_clk,
  input logic             wr_rst_n,
  input logic             wr_en,
  input logic             full,
  input logic [DEPTH-1:0] wr_ptr,
  input logic [DEPTH-1:0] wr_view,
  input logic             rd_clk,
  input logic             rd_rst_n,
  input logic             rd_en,
  input logic             empty,
  input logic [DEPTH-1:0] rd_ptr,
  input logic [DEPTH-1:0] rd_view,
  input logic [WIDTH-1:0] rd_data
);

  localparam int CAP = int'(rsf_pkg::usable_slots(DEPTH, SYNC_STAGES));

  AST_WPTR_ONEHOT: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $countones(wr_ptr) == 1); // R1

  AST_RPTR_ONEHOT: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $countones(rd_ptr) == 1); // R1

  AST_WPTR_HOLD: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    !(wr_en && !full) |=> $stable(wr_ptr)); // R2

  AST_RDATA_HOLD: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !(rd_en && !empty) |=> $stable(rd_data)); // R3

  AST_RPTR_HOLD: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !(rd_en && !empty) |=> $stable(rd_ptr)); // R3

  AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $countones(wr_view) <= CAP); // R6

  AST_FULL_AT_CAP: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    ($countones(wr_view) == CAP) |-> full); // R6

  AST_EMPTY_NO_DATA: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    ($countones(rd_view) == 0) |-> empty); // R5

endmodule

bind ring_status_fifo ring_status_fifo_checker #(
  .DEPTH       (DEPTH),
  .WIDTH       (WIDTH),
  .SYNC_STAGES (SYNC_STAGES)
) u_chk (
  .wr_clk   (wr_clk),
  .wr_rst_n (wr_rst_n),
  .wr_en    (wr_en),
  .full     (full),
  .wr_ptr   (wr_ptr),
  .wr_view  (wr_view),
  .rd_clk   (rd_clk),
  .rd_rst_n (rd_rst_n),
  .rd_en    (rd_en),
  .empty    (empty),
  .rd_ptr   (rd_ptr),
  .rd_view  (rd_view),
  .rd_data  (rd_data)
);

// File: tb/ring_status_fifo_bench.sv
`timescale 1ns/100ps
module ring_status_fifo_bench;

  localparam int unsigned DEPTH = 8;
  localparam int unsigned WIDTH = 8;
  localparam int unsigned SYNC  = 2;
  localparam int          CAP   = 6;
  localparam int          NPAT  = 6;

  // Each row: write-enable mask, read-enable mask, word count,
  // expected empty after draining, expected full after draining.
  localparam logic [25:0] PATTERNS [NPAT] = '{
    {8'hFF, 8'hFF, 8'd40, 1'b1, 1'b0},
    {8'hFF, 8'h11, 8'd30, 1'b1, 1'b0},
    {8'h11, 8'hFF, 8'd30, 1'b1, 1'b0},
    {8'hA5, 8'h5A, 8'd40, 1'b1, 1'b0},
    {8'hF0, 8'h0F, 8'd40, 1'b1, 1'b0},
    {8'h37, 8'hC9, 8'd40, 1'b1, 1'b0}
  };

  logic             wr_clk;
  logic             wr_arst_n;
  logic             wr_en;
  logic [WIDTH-1:0] wr_data;
  logic             full;
  logic             rd_clk;
  logic             rd_arst_n;
  logic             rd_en;
  logic [WIDTH-1:0] rd_data;
  logic             empty;

  int               n_checks;
  int               n_errs;
  int               wr_edges;
  int               rd_edges;
  logic [WIDTH-1:0] next_wr;
  logic [WIDTH-1:0] next_rd;

  ring_status_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH), .SYNC_STAGES(SYNC)) u_ring_status_fifo (
    .wr_clk    (wr_clk),
    .wr_arst_n (wr_arst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .full      (full),
    .rd_clk    (rd_clk),
    .rd_arst_n (rd_arst_n),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .empty     (empty)
  );

  // 125 MHz write clock; unrelated read clock whose edges never meet it.
  initial begin
    wr_clk = 1'b0;
    forever #4 wr_clk = ~wr_clk;
  end

  initial begin
    rd_clk = 1'b0;
    #1.1;
    forever #6.5 rd_clk = ~rd_clk;
  end

  initial wr_edges = 0;
  initial rd_edges = 0;
  always @(posedge wr_clk) wr_edges = wr_edges + 1;
  always @(posedge rd_clk) rd_edges = rd_edges + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks = n_checks + 1;
    if (!ok) begin
      n_errs = n_errs + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push_words(input logic [7:0] mask, input int n);
    int         sent = 0;
    logic [2:0] ph   = 3'd0;
    while (sent < n) begin
      @(negedge wr_clk);
      wr_en   = mask[ph];
      ph      = ph + 3'd1;
      wr_data = next_wr;
      if (wr_en && !full) begin
        sent    = sent + 1;
        next_wr = next_wr + 8'd1;
      end
    end
    @(negedge wr_clk);
    wr_en = 1'b0;
  endtask

  task automatic pull_words(input logic [7:0] mask, input int n, input string tag);
    int         got  = 0;
    bit         pend = 1'b0;
    logic [2:0] ph   = 3'd0;
    while (got < n) begin
      @(negedge rd_clk);
      if (pend) begin
        chk(rd_data == next_rd, tag, int'(rd_data), int'(next_rd));
        next_rd = next_rd + 8'd1;
        got     = got + 1;
        pend    = 1'b0;
      end
      rd_en = mask[ph] && (got < n);
      ph    = ph + 3'd1;
      pend  = rd_en && !empty;
    end
    rd_en = 1'b0;
  endtask

  // Watchdog: a hung run ends as a failure.
  initial begin
    repeat (150000) @(posedge wr_clk);
    n_checks = n_checks + 1;
    n_errs   = n_errs + 1;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    int         c0;
    int         acc;
    logic [7:0] held;
    n_checks  = 0;
    n_errs    = 0;
    next_wr   = 8'd1;
    next_rd   = 8'd1;
    wr_arst_n = 1'b0;
    rd_arst_n = 1'b0;
    wr_en     = 1'b0;
    rd_en     = 1'b0;
    wr_data   = '0;
    #30;
    wr_arst_n = 1'b1;
    rd_arst_n = 1'b1;
    repeat (6) @(negedge wr_clk);
    @(negedge rd_clk);

    // R4: state after reset.
    chk(empty == 1'b1, "R4 empty after reset", int'(empty), 1);
    chk(full == 1'b0, "R4 full after reset", int'(full), 0);
    chk(rd_data == '0, "R4 rd_data after reset", int'(rd_data), 0);

    // R7: empty falls SYNC read edges after one write.
    @(negedge wr_clk);
    wr_en   = 1'b1;
    wr_data = next_wr;
    @(posedge wr_clk);
    c0 = rd_edges;
    @(negedge wr_clk);
    wr_en   = 1'b0;
    next_wr = next_wr + 8'd1;
    do @(negedge rd_clk); while (empty);
    chk(rd_edges - c0 == SYNC, "R7 empty latency", rd_edges - c0, SYNC);

    // R3/R5: registered read of the only word, then empty again.
    rd_en = 1'b1;
    @(negedge rd_clk);
    rd_en = 1'b0;
    chk(rd_data == next_rd, "R3 read data timing", int'(rd_data), int'(next_rd));
    next_rd = next_rd + 8'd1;
    chk(empty == 1'b1, "R5 empty after last word", int'(empty), 1);

    // R3: requests while empty leave rd_data alone.
    held  = rd_data;
    rd_en = 1'b1;
    repeat (5) @(negedge rd_clk);
    rd_en = 1'b0;
    chk(rd_data == held, "R3 refused read holds data", int'(rd_data), int'(held));
    chk(empty == 1'b1, "R3 empty after refused reads", int'(empty), 1);

    // R6/R2: fill with no reads; refused words carry 8'hEE.
    acc = 0;
    repeat (20) begin
      @(negedge wr_clk);
      wr_en = 1'b1;
      if (full) begin
        wr_data = 8'hEE;
      end else begin
        wr_data = next_wr;
        next_wr = next_wr + 8'd1;
        acc     = acc + 1;
      end
    end
    @(negedge wr_clk);
    wr_en = 1'b0;
    chk(acc == CAP, "R6 accepted writes to full", acc, CAP);
    chk(full == 1'b1, "R6 full held with no reads", int'(full), 1);

    // R8: one read from full, full releases SYNC write edges later.
    @(negedge rd_clk);
    rd_en = 1'b1;
    @(posedge rd_clk);
    c0 = wr_edges;
    @(negedge rd_clk);
    rd_en = 1'b0;
    chk(rd_data == next_rd, "R3 read from full", int'(rd_data), int'(next_rd));
    next_rd = next_rd + 8'd1;
    do @(negedge wr_clk); while (full);
    chk(wr_edges - c0 == SYNC, "R8 full release latency", wr_edges - c0, SYNC);

    // R2: draining yields only the accepted words, never the refused ones.
    pull_words(8'hFF, CAP - 1, "R2 R5 drain after fill");
    repeat (4) @(negedge rd_clk);
    chk(empty == 1'b1, "R2 nothing extra stored", int'(empty), 1);

    // R1/R5: stimulus table, several wraps of the ring under mixed enables.
    for (int p = 0; p < NPAT; p++) begin
      fork
        push_words(PATTERNS[p][25:18], int'(PATTERNS[p][9:2]));
        pull_words(PATTERNS[p][17:10], int'(PATTERNS[p][9:2]), "R1 R5 stream order");
      join
      repeat (8) @(negedge wr_clk);
      @(negedge rd_clk);
      chk(empty == PATTERNS[p][1], "R5 empty after pattern", int'(empty), int'(PATTERNS[p][1]));
      chk(full == PATTERNS[p][0], "R2 full after pattern", int'(full), int'(PATTERNS[p][0]));
    end

    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

endmodule